// File: doc/BRIEF.md
# Cascadable LCD Segment Driver Core

This block is the digital core of a segment-column driver for a passive LCD with NUM_SEG outputs (80 by default). Display data comes in on a narrow bus, BUS_W bits wide (4 by default), one nibble per shift strobe. An enable token sets which nibble-wide slot of a data register takes the bus value. When every slot of the line has been written, the core raises its enable output so that the next driver in a chain takes over. No controller select line is needed. A falling edge on the load input copies the data register into an output latch and restarts the line. Each output is a 2-bit code that selects one of four drive voltages. The code depends on the latched bit, the frame alternation input and a blanking input.

Several cores are chained by connecting each en_out to the next core's en_in. The first core in the chain has en_in tied high. Fill progress is held in a three-state machine. ST_IDLE means no nibble of the current line has been taken. ST_FILL means a line is partly written. ST_FULL means all SLOTS = NUM_SEG/BUS_W slots are written and the enable has been passed on.

The machine has these transitions:
- first_capture: ST_IDLE to ST_FILL.
- last_capture: ST_FILL to ST_FULL. This is taken directly from ST_IDLE when SLOTS is 1.
- line_restart: any state to ST_IDLE, on a load falling edge.

When a capture falls in the same cycle as a load falling edge, that nibble starts the new line. While the core is not capturing, its internal gated data bus is held at zero.

Top module: `seg_drv_core`

## Requirements
- R1: After reset, en_out is 0 and both the data register and the output latch hold all zeros.
- R2: A nibble is captured only on a clock where shift_stb and en_in are both 1 and the core is not in ST_FULL. Strobes at any other time leave the data register unchanged.
- R3: With dir_up = 1, the n-th nibble of a line (n = 0 .. SLOTS-1) is written to segments BUS_W*n .. BUS_W*n+BUS_W-1. Bit i of the nibble goes to segment BUS_W*n+i.
- R4: With dir_up = 0, the n-th nibble of a line is written to segments BUS_W*(SLOTS-1-n)+i, with bit i of the nibble going to the segment at offset i.
- R5: en_out becomes 1 on the clock edge that captures the last nibble of a line. It stays 1 and further strobes are ignored until the next load falling edge.
- R6: The output latch changes only on a load falling edge, which is a clock where load is sampled 0 after being sampled 1. On that edge the latch takes the whole data register.
- R7: A load falling edge clears en_out and returns the write position to the first slot of the current direction.
- R8: With disp_off = 0, each 2-bit seg_code field is set from its latched bit d and the frame input f:
  - d=1, f=1 gives 00 (V0)
  - d=1, f=0 gives 11 (V5)
  - d=0, f=1 gives 01 (V2)
  - d=0, f=0 gives 10 (V3)
- R9: With disp_off = 1, every seg_code field is 00 (V0).
- R10: If a capture happens on the same edge as a load falling edge, the latch gets the data register as it was before that edge. The captured nibble becomes nibble 0 of the new line.
- R11: A load falling edge does not clear the data register. Slots that a partial line does not rewrite keep their earlier contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| en_in | input | 1 | Enable from the previous core in the chain (tied high on the first core) |
| shift_stb | input | 1 | Shift strobe; one nibble offered per clock where it is high |
| dir_up | input | 1 | Fill direction: 1 fills from segment 0 upward, 0 from the top segment downward |
| data_in | input | BUS_W | Display data nibble |
| en_out | output | 1 | Enable to the next core; high while the line is full |
| load | input | 1 | Load pulse; its falling edge latches the line and restarts filling |
| frame | input | 1 | Frame alternation signal |
| disp_off | input | 1 | Blanking; forces every output to the V0 code |
| seg_code | output | 2*NUM_SEG | Drive-level select, two bits per segment, segment k in bits 2k+1:2k |

## Verification
The delicate case is a load falling edge and a nibble capture landing on the same clock edge. The restart of the token and the latch copy then race the write into slot 0. The bench provokes this by dropping load on the same clock where it raises shift_stb. It then judges the outcome in two stages. First, the latched outputs must show the line from before that edge in all four frame and blanking combinations. Second, after nineteen more strobes and a further load, the outputs must show the simultaneous nibble in the first slot of the new line and en_out must have risen on exactly the twentieth capture.

// File: rtl/seg_drv_pkg.sv
package seg_drv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_FILL = 2'b01,
        ST_FULL = 2'b10
    } fill_state_e;

    typedef enum logic [1:0] {
        LVL_V0 = 2'b00,
        LVL_V2 = 2'b01,
        LVL_V3 = 2'b10,
        LVL_V5 = 2'b11
    } drive_lvl_e;

endpackage

// File: rtl/seg_enable_chain.sv
module seg_enable_chain
    import seg_drv_pkg::*;
#(
    parameter int SLOTS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_in,
    input  logic             shift_stb,
    input  logic             dir_up,
    input  logic             restart,
    output logic             capture,
    output logic [SLOTS-1:0] wr_sel,
    output logic             en_out
);

    localparam int CW = $clog2(SLOTS + 1);
    localparam logic [SLOTS-1:0] POS_LOW  = SLOTS'(1);
    localparam logic [SLOTS-1:0] POS_HIGH = POS_LOW << (SLOTS - 1);

    fill_state_e      state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d, base_cnt;
    logic [SLOTS-1:0] token_q, token_d;
    logic             line_start, last_slot;

    // a fresh line starts either from idle or on the restart edge itself
    assign line_start = restart || (state_q == ST_IDLE);
    assign wr_sel     = line_start ? (dir_up ? POS_LOW : POS_HIGH) : token_q;
    assign base_cnt   = line_start ? '0 : cnt_q;
    assign last_slot  = (base_cnt == CW'(SLOTS - 1));
    assign capture    = en_in && shift_stb && (restart || (state_q != ST_FULL));

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        token_d = token_q;
        unique case (state_q)
            ST_IDLE: begin
                if (capture) state_d = last_slot ? ST_FULL : ST_FILL; // first_capture
            end
            ST_FILL: begin
                if (capture && last_slot) state_d = ST_FULL;          // last_capture
            end
            ST_FULL: begin
                state_d = ST_FULL;
            end
            default: state_d = ST_IDLE;
        endcase
        if (restart) begin                                            // line_restart
            state_d = ST_IDLE;
            cnt_d   = '0;
        end
        if (capture) begin
            cnt_d   = base_cnt + CW'(1);
            token_d = dir_up ? (wr_sel << 1) : (wr_sel >> 1);
            if (restart) state_d = last_slot ? ST_FULL : ST_FILL;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            token_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            token_q <= token_d;
        end
    end

    // outputs
    always_comb begin
        en_out = (state_q == ST_FULL);
    end

endmodule

// File: rtl/seg_data_reg.sv
module seg_data_reg #(
    parameter int SLOTS = 20,
    parameter int BUS_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   capture,
    input  logic [SLOTS-1:0]       wr_sel,
    input  logic [BUS_W-1:0]       data_in,
    output logic [SLOTS*BUS_W-1:0] data_q
);

    logic [BUS_W-1:0] bus_gated;

    // internal bus held low whenever nothing is being captured
    assign bus_gated = capture ? data_in : '0;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[k*BUS_W +: BUS_W] <= '0;
            else if (capture && wr_sel[k])
                data_q[k*BUS_W +: BUS_W] <= bus_gated;
        end
    end

endmodule

// File: rtl/seg_level_enc.sv
module seg_level_enc
    import seg_drv_pkg::*;
#(
    parameter int NUM_SEG = 80
) (
    input  logic [NUM_SEG-1:0]   latch_q,
    input  logic                 frame,
    input  logic                 disp_off,
    output logic [2*NUM_SEG-1:0] seg_code
);

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        drive_lvl_e lvl;
        always_comb begin
            if (disp_off)
                lvl = LVL_V0;
            else begin
                unique case ({latch_q[s], frame})
                    2'b11:   lvl = LVL_V0;
                    2'b10:   lvl = LVL_V5;
                    2'b01:   lvl = LVL_V2;
                    default: lvl = LVL_V3;
                endcase
            end
        end
        assign seg_code[2*s +: 2] = lvl;
    end

endmodule

// File: rtl/seg_drv_core.sv
module seg_drv_core
    import seg_drv_pkg::*;
#(
    parameter int NUM_SEG = 80,
    parameter int BUS_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_in,
    input  logic                 shift_stb,
    input  logic                 dir_up,
    input  logic [BUS_W-1:0]     data_in,
    output logic                 en_out,
    input  logic                 load,
    input  logic                 frame,
    input  logic                 disp_off,
    output logic [2*NUM_SEG-1:0] seg_code
);

    localparam int SLOTS = NUM_SEG / BUS_W;

    logic                 load_q, load_fall, capture;
    logic [SLOTS-1:0]     wr_sel;
    logic [NUM_SEG-1:0]   data_q, latch_q;

    assign load_fall = load_q && !load;

    seg_enable_chain #(.SLOTS(SLOTS)) i_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_in     (en_in),
        .shift_stb (shift_stb),
        .dir_up    (dir_up),
        .restart   (load_fall),
        .capture   (capture),
        .wr_sel    (wr_sel),
        .en_out    (en_out)
    );

    seg_data_reg #(.SLOTS(SLOTS), .BUS_W(BUS_W)) i_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .wr_sel  (wr_sel),
        .data_in (data_in),
        .data_q  (data_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= 1'b0;
            latch_q <= '0;
        end else begin
            load_q <= load;
            if (load_fall) latch_q <= data_q;
        end
    end

    seg_level_enc #(.NUM_SEG(NUM_SEG)) i_enc (
        .latch_q  (latch_q),
        .frame    (frame),
        .disp_off (disp_off),
        .seg_code (seg_code)
    );

endmodule

// File: rtl/seg_drv_chk.sv
module seg_drv_chk #(
    parameter int NUM_SEG = 80
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en_in,
    input logic                 shift_stb,
    input logic                 load,
    input logic                 frame,
    input logic                 disp_off,
    input logic                 en_out,
    input logic [2*NUM_SEG-1:0] seg_code
);

    // R9
    blank_all_v0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_off |-> (seg_code == '0));

    // R5
    en_out_rise_on_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_out) |-> $past(shift_stb && en_in));

    // R7
    en_out_clear_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(load)) |=> !en_out);

    // R5
    en_out_held_until_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_out) |-> ($past(!load) && $past(load, 2)));

    // R6
    latch_only_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(frame) && $stable(disp_off) && !($past(!load) && $past(load, 2)))
            |-> $stable(seg_code));

endmodule

bind seg_drv_core seg_drv_chk #(.NUM_SEG(NUM_SEG)) i_seg_drv_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_in     (en_in),
    .shift_stb (shift_stb),
    .load      (load),
    .frame     (frame),
    .disp_off  (disp_off),
    .en_out    (en_out),
    .seg_code  (seg_code)
);

// File: tb/test_seg_drv_core.sv
module test_seg_drv_core;

    localparam int CLK_PERIOD = 10;
    localparam int NUM_SEG    = 80;
    localparam int BUS_W      = 4;
    localparam int SLOTS      = NUM_SEG / BUS_W;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 en_in = 1'b0;
    logic                 shift_stb = 1'b0;
    logic                 dir_up = 1'b1;
    logic [BUS_W-1:0]     data_in = '0;
    logic                 en_out;
    logic                 load = 1'b0;
    logic                 frame = 1'b0;
    logic                 disp_off = 1'b0;
    logic [2*NUM_SEG-1:0] seg_code;

    int vectors = 0;
    int miscompares = 0;
    bit reported = 0;

    logic [NUM_SEG-1:0] exp_reg = '0;
    logic [NUM_SEG-1:0] exp_latch = '0;
    int                 exp_cnt = 0;
    bit                 exp_full = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    seg_drv_core #(.NUM_SEG(NUM_SEG), .BUS_W(BUS_W)) i_seg_drv_core (
        .clk(clk), .rst_n(rst_n), .en_in(en_in), .shift_stb(shift_stb),
        .dir_up(dir_up), .data_in(data_in), .en_out(en_out), .load(load),
        .frame(frame), .disp_off(disp_off), .seg_code(seg_code)
    );

    function automatic logic [1:0] exp_code(logic d, logic f, logic off);
        if (off) return 2'b00;
        case ({d, f})
            2'b11:   return 2'b00;
            2'b10:   return 2'b11;
            2'b01:   return 2'b01;
            default: return 2'b10;
        endcase
    endfunction

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_en(string tag);
        vectors++;
        if (en_out !== exp_full) begin
            miscompares++;
            $display("FAIL %s en_out actual=%0b expected=%0b", tag, en_out, exp_full);
        end
    endtask

    // sweeps all frame/blanking combinations over every segment
    task automatic check_outputs(string tag);
        for (int off = 0; off < 2; off++) begin
            for (int f = 0; f < 2; f++) begin
                disp_off = off[0];
                frame    = f[0];
                #1;
                for (int s = 0; s < NUM_SEG; s++) begin
                    logic [1:0] e;
                    e = exp_code(exp_latch[s], f[0], off[0]);
                    vectors++;
                    if (seg_code[2*s +: 2] !== e) begin
                        miscompares++;
                        $display("FAIL %s seg %0d off=%0d frame=%0d actual=%b expected=%b",
                                 tag, s, off, f, seg_code[2*s +: 2], e);
                    end
                end
            end
        end
        disp_off = 1'b0;
        frame    = 1'b0;
    endtask

    function automatic void model_capture(logic [BUS_W-1:0] nib);
        int pos;
        if (en_in && !exp_full) begin
            pos = dir_up ? exp_cnt : SLOTS - 1 - exp_cnt;
            exp_reg[pos*BUS_W +: BUS_W] = nib;
            exp_cnt++;
            exp_full = (exp_cnt == SLOTS);
        end
    endfunction

    task automatic strobe(logic [BUS_W-1:0] nib, string tag);
        data_in   = nib;
        shift_stb = 1'b1;
        step();
        model_capture(nib);
        shift_stb = 1'b0;
        data_in   = '0;
        check_en(tag);
    endtask

    task automatic pulse_load(string tag);
        load = 1'b1;
        step();
        load = 1'b0;
        step();
        exp_latch = exp_reg;
        exp_cnt   = 0;
        exp_full  = 0;
        check_en(tag);
    endtask

    task automatic fill_line(int seed, int count, string tag);
        for (int k = 0; k < count; k++)
            strobe(BUS_W'((k * 7 + seed * 3 + 1) & 15), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state, R8 mapping of all-zero latch
        check_en("R1");
        check_outputs("R1_R8");

        // R2: strobes while en_in is low leave the register untouched
        en_in = 1'b0;
        fill_line(9, 5, "R2");
        pulse_load("R2");
        check_outputs("R2");

        // R3 upward line, R5 enable handoff and full-ignore
        en_in  = 1'b1;
        dir_up = 1'b1;
        fill_line(1, SLOTS, "R5");
        strobe(4'hF, "R5_full_ignore");
        strobe(4'h0, "R5_full_ignore");
        check_outputs("R6_before_load");
        pulse_load("R7");
        check_outputs("R3_R8_R9");

        // R4 downward line
        dir_up = 1'b0;
        fill_line(2, SLOTS, "R4");
        pulse_load("R7");
        check_outputs("R4");

        // R11 partial line keeps untouched slots; R7 position restarts
        dir_up = 1'b1;
        fill_line(3, 7, "R11");
        pulse_load("R11");
        check_outputs("R11");

        // R10 capture on the same edge as a load falling edge
        dir_up    = 1'b0;
        load      = 1'b1;
        step();
        load      = 1'b0;
        data_in   = 4'hA;
        shift_stb = 1'b1;
        step();
        shift_stb = 1'b0;
        data_in   = '0;
        exp_latch = exp_reg;
        exp_cnt   = 0;
        exp_full  = 0;
        model_capture(4'hA);
        check_en("R10");
        check_outputs("R10_old_line");
        fill_line(4, SLOTS - 1, "R10");
        pulse_load("R10");
        check_outputs("R10_new_line");

        // another upward line after the simultaneous case
        dir_up = 1'b1;
        fill_line(5, SLOTS, "R3");
        pulse_load("R3");
        check_outputs("R3");

        summary();
        $finish;
    end

endmodule